// File: doc/BRIEF.md
# Per-Pixel Hit Timestamp Recorder

This block is the digital store inside a single detector pixel. When the pixel's comparator fires, the block copies the value on a shared timestamp bus into a small local set of cells. A fill pointer then moves to the next free cell, so a later hit in the same bunch train lands in the following cell. Hits that arrive when every cell is full are discarded, and a sticky overflow bit records that this happened. Every bunch train begins with a clear, which rewinds the pointer and clears the overflow bit.

Readout takes place between trains. A cell-select input picks one stored word, and a valid flag marks whether that cell holds a recorded timestamp. An empty flag tells the readout sequencer that the pixel holds nothing, so the sequencer can skip it without spending cycles on it. For test, a broadcast write copies the bus value into every cell in one cycle. The cells can then be read back one at a time.

Top module: `ptx_hit_recorder`

## Requirements
- R1: After reset the pixel has no stored cells. `px_empty` is 1, `rd_valid` is 0, `rd_data` is 0 and `ovf_flag` is 0, for any `rd_sel`.
- R2: On a rising edge of `hit_in` (high this cycle, low the cycle before), `ts_bus` is stored into the cell at the fill pointer and the pointer advances. Cell 0 fills first and cell 1 second. The new word is readable after that clock edge.
- R3: A `hit_in` held high across several cycles records only one timestamp.
- R4: A hit rising edge while all cells are full stores nothing and leaves the cells unchanged. It sets `ovf_flag`, which stays 1 until a train clear or a reset.
- R5: `train_clr` rewinds the fill pointer to zero and clears `ovf_flag`. It takes priority over a hit and over a test write in the same cycle, so a hit in that cycle is not recorded.
- R6: `px_empty` is 1 exactly when no cell holds a recorded timestamp.
- R7: `rd_valid` is 1 exactly when `rd_sel` is below the number of filled cells. In that case `rd_data` is the word in cell `rd_sel`. Otherwise `rd_data` is 0.
- R8: `tst_wr` (without `train_clr`) writes `ts_bus` into every cell in the same clock and marks all cells filled. It leaves `ovf_flag` unchanged.
- R9: When `tst_wr` and a hit rising edge fall in the same cycle, the test write wins. Every cell holds the bus value, and a later hit is treated as arriving on full cells.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hit_in | input | 1 | Comparator output (hit when it rises) |
| ts_bus | input | TS_W (14) | Shared timestamp bus, also the test-write data |
| train_clr | input | 1 | Clear at the start of a bunch train |
| tst_wr | input | 1 | Broadcast test write into every cell |
| rd_sel | input | SEL_W (1) | Readout cell select |
| rd_data | output | TS_W (14) | Selected stored word, 0 when not valid |
| rd_valid | output | 1 | Selected cell holds a recorded word |
| px_empty | output | 1 | No cell filled |
| ovf_flag | output | 1 | Sticky: a hit was dropped on full cells |

## Verification
The assertions assume `hit_in`, `train_clr` and `tst_wr` are synchronous to `clk` and settle well before each rising edge. Their edge-based checks also depend on the previous sample of `hit_in` starting at 0 out of reset. The bench meets these conditions by changing every input only on the falling clock edge, by holding `hit_in` low during reset, and by reading the outputs two nanoseconds after the rising edge. Every hit used to fill a cell is preceded by a cycle with `hit_in` low, so each one is a true rising edge. The only exceptions are the rows that test a held comparator level on purpose.

// File: rtl/ptx_pkg.sv
package ptx_pkg;
   // One action per clock, already resolved by priority
   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_CLEAR = 2'd1,
      OP_BCAST = 2'd2,
      OP_HIT   = 2'd3
   } ptx_op_e;

   function automatic ptx_op_e pick_op(input logic clr, input logic bcast, input logic rise);
      if (clr)        return OP_CLEAR;
      else if (bcast) return OP_BCAST;
      else if (rise)  return OP_HIT;
      else            return OP_IDLE;
   endfunction
endpackage

// File: rtl/ptx_edge.sv
module ptx_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic level_in,
   output logic rise_out
);
   logic level_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) level_q <= 1'b0;
      else        level_q <= level_in;
   end

   assign rise_out = level_in & ~level_q;
endmodule

// File: rtl/ptx_ctrl.sv
module ptx_ctrl
   import ptx_pkg::*;
#(
   parameter int NCELLS = 2,
   localparam int CNT_W = $clog2(NCELLS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  ptx_op_e           op,
   output logic [CNT_W-1:0]  fill_cnt,
   output logic              ovf,
   output logic [NCELLS-1:0] cell_we
);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(NCELLS);

   logic [CNT_W-1:0] fill_q;
   logic             ovf_q;
   logic             full;

   assign full = (fill_q == FULL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fill_q <= '0;
         ovf_q  <= 1'b0;
      end else begin
         unique case (op)
            OP_CLEAR: begin
               fill_q <= '0;
               ovf_q  <= 1'b0;
            end
            OP_BCAST: fill_q <= FULL;
            OP_HIT: begin
               if (full) ovf_q  <= 1'b1;
               else      fill_q <= fill_q + 1'b1;
            end
            default: ;
         endcase
      end
   end

   for (genvar c = 0; c < NCELLS; c++) begin : g_we
      assign cell_we[c] = (op == OP_BCAST) ||
                          ((op == OP_HIT) && (fill_q == CNT_W'(c)));
   end

   assign fill_cnt = fill_q;
   assign ovf      = ovf_q;
endmodule

// File: rtl/ptx_store.sv
module ptx_store #(
   parameter int TS_W   = 14,
   parameter int NCELLS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NCELLS-1:0] we,
   input  logic [TS_W-1:0]   din,
   output logic [TS_W-1:0]   cells [NCELLS]
);
   for (genvar c = 0; c < NCELLS; c++) begin : g_cell
      logic [TS_W-1:0] word_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     word_q <= '0;
         else if (we[c]) word_q <= din;
      end
      assign cells[c] = word_q;
   end
endmodule

// File: rtl/ptx_rdmux.sv
module ptx_rdmux #(
   parameter int TS_W   = 14,
   parameter int NCELLS = 2,
   localparam int SEL_W = (NCELLS > 1) ? $clog2(NCELLS) : 1,
   localparam int CNT_W = $clog2(NCELLS + 1)
) (
   input  logic [SEL_W-1:0] sel,
   input  logic [CNT_W-1:0] fill_cnt,
   input  logic [TS_W-1:0]  cells [NCELLS],
   output logic [TS_W-1:0]  data,
   output logic             valid
);
   if (NCELLS == 1) begin : g_single
      assign valid = (sel == '0) && (fill_cnt != '0);
      assign data  = valid ? cells[0] : '0;
   end else begin : g_multi
      logic [CNT_W-1:0] sel_ext;
      assign sel_ext = CNT_W'(sel);
      assign valid   = sel_ext < fill_cnt;
      always_comb begin
         data = '0;
         for (int c = 0; c < NCELLS; c++) begin
            if (valid && (sel == SEL_W'(c))) data = cells[c];
         end
      end
   end
endmodule

// File: rtl/ptx_hit_recorder.sv
module ptx_hit_recorder
   import ptx_pkg::*;
#(
   parameter int TS_W   = 14,
   parameter int NCELLS = 2,
   localparam int SEL_W = (NCELLS > 1) ? $clog2(NCELLS) : 1,
   localparam int CNT_W = $clog2(NCELLS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hit_in,
   input  logic [TS_W-1:0]  ts_bus,
   input  logic             train_clr,
   input  logic             tst_wr,
   input  logic [SEL_W-1:0] rd_sel,
   output logic [TS_W-1:0]  rd_data,
   output logic             rd_valid,
   output logic             px_empty,
   output logic             ovf_flag
);
   if (TS_W < 1) begin : g_bad_width
      $error("ptx_hit_recorder: TS_W must be at least 1");
   end
   if (NCELLS < 1 || NCELLS > 64) begin : g_bad_depth
      $error("ptx_hit_recorder: NCELLS must lie in 1..64");
   end

   logic              hit_rise;
   ptx_op_e           op;
   logic [CNT_W-1:0]  fill_cnt;
   logic [NCELLS-1:0] cell_we;
   logic [TS_W-1:0]   cells [NCELLS];

   ptx_edge u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .level_in (hit_in),
      .rise_out (hit_rise)
   );

   assign op = pick_op(train_clr, tst_wr, hit_rise);

   ptx_ctrl #(.NCELLS(NCELLS)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .op       (op),
      .fill_cnt (fill_cnt),
      .ovf      (ovf_flag),
      .cell_we  (cell_we)
   );

   ptx_store #(.TS_W(TS_W), .NCELLS(NCELLS)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cell_we),
      .din   (ts_bus),
      .cells (cells)
   );

   ptx_rdmux #(.TS_W(TS_W), .NCELLS(NCELLS)) u_rdmux (
      .sel      (rd_sel),
      .fill_cnt (fill_cnt),
      .cells    (cells),
      .data     (rd_data),
      .valid    (rd_valid)
   );

   assign px_empty = (fill_cnt == '0);
endmodule

// File: rtl/ptx_hit_recorder_chk.sv
module ptx_hit_recorder_chk #(
   parameter int TS_W   = 14,
   parameter int NCELLS = 2,
   localparam int SEL_W = (NCELLS > 1) ? $clog2(NCELLS) : 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             hit_in,
   input logic [TS_W-1:0]  ts_bus,
   input logic             train_clr,
   input logic             tst_wr,
   input logic [SEL_W-1:0] rd_sel,
   input logic [TS_W-1:0]  rd_data,
   input logic             rd_valid,
   input logic             px_empty,
   input logic             ovf_flag
);
   logic hit_prev;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hit_prev <= 1'b0;
      else        hit_prev <= hit_in;
   end

   AST_EMPTY_NOT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      px_empty |-> !rd_valid);                                          // R6
   AST_INVALID_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_valid |-> (rd_data == '0));                                   // R7
   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flag && !train_clr) |=> ovf_flag);                           // R4
   AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      train_clr |=> (px_empty && !ovf_flag));                           // R5
   AST_BCAST_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
      (tst_wr && !train_clr) |=> !px_empty);                            // R8
   AST_HIT_RECORDS: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_in && !hit_prev && !train_clr && px_empty) |=> !px_empty);   // R2
   AST_OVF_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      (!ovf_flag && !(hit_in && !hit_prev)) |=> !ovf_flag);             // R4
endmodule

bind ptx_hit_recorder ptx_hit_recorder_chk #(.TS_W(TS_W), .NCELLS(NCELLS)) chk_i (.*);

// File: tb/ptx_hit_recorder_tb.sv
module ptx_hit_recorder_tb_top;
   localparam int TS_W  = 14;
   localparam int NVEC  = 13;
   localparam int VEC_W = 35;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            hit_in = 1'b0;
   logic [TS_W-1:0] ts_bus = '0;
   logic            train_clr = 1'b0;
   logic            tst_wr = 1'b0;
   logic [0:0]      rd_sel = '0;
   logic [TS_W-1:0] rd_data;
   logic            rd_valid;
   logic            px_empty;
   logic            ovf_flag;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   ptx_hit_recorder dut_i (
      .clk(clk), .rst_n(rst_n), .hit_in(hit_in), .ts_bus(ts_bus),
      .train_clr(train_clr), .tst_wr(tst_wr), .rd_sel(rd_sel),
      .rd_data(rd_data), .rd_valid(rd_valid), .px_empty(px_empty), .ovf_flag(ovf_flag)
   );

   // {clr, tst, hit, ts[13:0], sel, exp_empty, exp_valid, exp_data[13:0], exp_ovf}
   localparam logic [VEC_W-1:0] VEC [NVEC] = '{
      {1'b1,1'b0,1'b0,14'h0000,1'b0, 1'b1,1'b0,14'h0000,1'b0}, // R5 clear
      {1'b0,1'b0,1'b1,14'h0101,1'b0, 1'b0,1'b1,14'h0101,1'b0}, // R2 first hit
      {1'b0,1'b0,1'b1,14'h0202,1'b1, 1'b0,1'b0,14'h0000,1'b0}, // R3 held
      {1'b0,1'b0,1'b0,14'h0303,1'b0, 1'b0,1'b1,14'h0101,1'b0}, // R7
      {1'b0,1'b0,1'b1,14'h0404,1'b1, 1'b0,1'b1,14'h0404,1'b0}, // R2 second
      {1'b0,1'b0,1'b0,14'h0000,1'b1, 1'b0,1'b1,14'h0404,1'b0}, // R7
      {1'b0,1'b0,1'b1,14'h0505,1'b0, 1'b0,1'b1,14'h0101,1'b1}, // R4 drop
      {1'b0,1'b0,1'b0,14'h0000,1'b1, 1'b0,1'b1,14'h0404,1'b1}, // R4 sticky
      {1'b1,1'b0,1'b1,14'h0606,1'b0, 1'b1,1'b0,14'h0000,1'b0}, // R5 clr beats hit
      {1'b0,1'b0,1'b0,14'h0000,1'b0, 1'b1,1'b0,14'h0000,1'b0}, // R6
      {1'b0,1'b0,1'b1,14'h3FFF,1'b0, 1'b0,1'b1,14'h3FFF,1'b0}, // R2 max value
      {1'b0,1'b1,1'b0,14'h1234,1'b1, 1'b0,1'b1,14'h1234,1'b0}, // R8 bcast
      {1'b0,1'b0,1'b0,14'h0000,1'b0, 1'b0,1'b1,14'h1234,1'b0}  // R8 readback
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic step(input logic c, input logic t, input logic h,
                       input logic [TS_W-1:0] ts, input logic s);
      @(negedge clk);
      train_clr = c; tst_wr = t; hit_in = h; ts_bus = ts; rd_sel = s;
      @(posedge clk);
      #2;
   endtask

   task automatic look(input logic s, input string req, input logic e_empty,
                       input logic e_valid, input logic [TS_W-1:0] e_data, input logic e_ovf);
      rd_sel = s;
      #1;
      chk({req, " empty"}, 32'(px_empty), 32'(e_empty));
      chk({req, " valid"}, 32'(rd_valid), 32'(e_valid));
      chk({req, " data"},  32'(rd_data),  32'(e_data));
      chk({req, " ovf"},   32'(ovf_flag), 32'(e_ovf));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      look(1'b0, "R1 sel0", 1'b1, 1'b0, '0, 1'b0);
      look(1'b1, "R1 sel1", 1'b1, 1'b0, '0, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NVEC; i++) begin
         logic [VEC_W-1:0] v;
         v = VEC[i];
         step(v[34], v[33], v[32], v[31:18], v[17]);
         look(v[17], $sformatf("vec%0d", i), v[16], v[15], v[14:1], v[0]);
      end

      // R9: test write and hit rising edge in the same cycle
      step(1'b1, 1'b0, 1'b0, '0, 1'b0);
      step(1'b0, 1'b0, 1'b0, '0, 1'b0);
      step(1'b0, 1'b1, 1'b1, 14'h0777, 1'b0);
      look(1'b0, "R9 cell0", 1'b0, 1'b1, 14'h0777, 1'b0);
      look(1'b1, "R9 cell1", 1'b0, 1'b1, 14'h0777, 1'b0);
      step(1'b0, 1'b0, 1'b0, '0, 1'b0);
      step(1'b0, 1'b0, 1'b1, 14'h0888, 1'b0);
      look(1'b0, "R9 full c0", 1'b0, 1'b1, 14'h0777, 1'b1);
      look(1'b1, "R9 full c1", 1'b0, 1'b1, 14'h0777, 1'b1);

      // R8: test write leaves the overflow bit as it is
      step(1'b0, 1'b1, 1'b0, 14'h2AAA, 1'b1);
      look(1'b0, "R8 ovf kept c0", 1'b0, 1'b1, 14'h2AAA, 1'b1);
      look(1'b1, "R8 ovf kept c1", 1'b0, 1'b1, 14'h2AAA, 1'b1);

      // R1: reset mid-run returns the empty state
      @(negedge clk);
      tst_wr = 1'b0; hit_in = 1'b0;
      rst_n = 1'b0;
      #2;
      look(1'b0, "R1 rerst c0", 1'b1, 1'b0, '0, 1'b0);
      look(1'b1, "R1 rerst c1", 1'b1, 1'b0, '0, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      step(1'b0, 1'b0, 1'b1, 14'h0042, 1'b0);
      look(1'b0, "R2 after rst", 1'b0, 1'b1, 14'h0042, 1'b0);
      look(1'b1, "R7 after rst", 1'b0, 1'b0, 14'h0000, 1'b0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #400000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule